// File: doc/BRIEF.md
# Multicore Core-Start Configuration Registers

This block sits on a simple 32-bit peripheral register bus with a setup phase and an access phase. It brings up the secondary cores of a four-core cluster. Software first stores a boot address in the entry address register. It then writes any nonzero value to the reset control word of the chosen core. In the cycle after that write completes, the block issues a one-cycle start request. The request carries the core number, the stored boot address and the start privilege level, which is fixed at 3, the highest level.

The block also holds two read/write scratch and control words: a general control word and a standby flag. Several status and reset words return fixed values. A small group of offsets is reserved but not implemented. An access to one of them is flagged as unimplemented. An access to any other offset inside the 1 KiB window that nothing decodes, including an offset that is not 32-bit aligned, returns a slave error. The bus has no wait states. Read data and both flags are valid during the access phase.

Top module: `cpucfg_top`

## Requirements
- R1: After reset the general control word (0x184) reads 0x00000020, the standby flag (0x1A0) reads 0 and the entry address (0x1A4) reads 0.
- R2: The words at 0x184, 0x1A0 and 0x1A4 store all 32 written bits and read them back unchanged.
- R3: A write with nonzero data to offset 0x40 + 0x40*N (N = 0..3) makes start_valid high for exactly the one cycle after the access phase. In that cycle start_core = N, start_addr = the current entry address and start_level = 3.
- R4: A write of zero to a core reset word does not raise start_valid. No access of any other kind raises start_valid either.
- R5: Fixed words read as follows and ignore writes. Core reset (0x40 + 0x40*N) reads 0x3. Core control (+0x4) reads 0. Core status (+0x8) reads 0x1. Cluster reset (0x000) and system reset (0x140) read 0x1. Clock gating (0x144) reads 0x10F.
- R6: Offsets 0x1E4, 0x280, 0x284 and 0x288 read 0 and ignore writes. During the access phase they raise unimpl_hit and do not raise pslverr.
- R7: Any other offset, including any offset with paddr[1:0] != 0, reads 0. During the access phase it raises pslverr, and it changes no state.
- R8: pslverr and unimpl_hit are high only during an access phase, and never both at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Block select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 10 | Byte offset within the 1 KiB window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during the access phase |
| pslverr | output | 1 | Slave error for an undecoded or misaligned offset |
| unimpl_hit | output | 1 | Access to a reserved, unimplemented offset |
| start_valid | output | 1 | One-cycle core start request |
| start_core | output | 2 | Index of the core to start |
| start_addr | output | 32 | Boot address for that core |
| start_level | output | 2 | Start privilege level, always 3 |

## Verification
Directed cases cover the reset values and one start request for each core, each with its own entry address. This shows that the core index comes from the offset and the address comes from the stored register. A zero write to each reset word, and writes to every fixed and reserved word, show that only nonzero reset writes fire a request and that nothing else disturbs stored state. Misaligned offsets next to valid ones, such as 0x41 and 0x1A6, tell an alignment failure apart from a decode hit. Constrained random accesses over the whole window are then compared with a bench model of each word's class. This shows that the error, unimplemented and read-value paths never overlap.

// File: rtl/cpucfg_pkg.sv
package cpucfg_pkg;

    localparam int ADDR_W      = 10;
    localparam int DATA_W      = 32;
    localparam int NUM_CORES   = 4;
    localparam int CORE_W      = $clog2(NUM_CORES);
    localparam int LEVEL_W     = 2;
    localparam int CORE_STRIDE = 'h40;
    localparam int STRIDE_LSB  = $clog2(CORE_STRIDE);
    localparam int NUM_RW      = 3;

    localparam logic [ADDR_W-1:0] OFF_CLUSTER_RST = 10'h000;
    localparam logic [ADDR_W-1:0] OFF_CORE_BASE   = 10'h040;
    localparam logic [ADDR_W-1:0] OFF_CORE_END    = OFF_CORE_BASE + ADDR_W'(NUM_CORES * CORE_STRIDE);
    localparam logic [ADDR_W-1:0] OFF_SYS_RST     = 10'h140;
    localparam logic [ADDR_W-1:0] OFF_CLKGATE     = 10'h144;
    localparam logic [ADDR_W-1:0] OFF_GEN         = 10'h184;
    localparam logic [ADDR_W-1:0] OFF_STBY        = 10'h1A0;
    localparam logic [ADDR_W-1:0] OFF_ENTRY       = 10'h1A4;
    localparam logic [ADDR_W-1:0] OFF_DBG         = 10'h1E4;
    localparam logic [ADDR_W-1:0] OFF_CNT_CTL     = 10'h280;
    localparam logic [ADDR_W-1:0] OFF_CNT_LO      = 10'h284;
    localparam logic [ADDR_W-1:0] OFF_CNT_HI      = 10'h288;

    localparam logic [DATA_W-1:0]  VAL_GLOBAL_RST = 32'h1;
    localparam logic [DATA_W-1:0]  VAL_CORE_RST   = 32'h3;
    localparam logic [DATA_W-1:0]  VAL_CORE_STAT  = 32'h1;
    localparam logic [DATA_W-1:0]  VAL_CLKGATE    = 32'h10F;
    localparam logic [LEVEL_W-1:0] START_LEVEL    = 2'd3;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_GLOBAL_RST,
        SEL_CORE_RST,
        SEL_CORE_CTRL,
        SEL_CORE_STAT,
        SEL_CLKGATE,
        SEL_GEN,
        SEL_STBY,
        SEL_ENTRY,
        SEL_UNIMPL
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e          sel;
        logic [CORE_W-1:0] core;
    } reg_hit_t;

    typedef struct packed {
        logic [CORE_W-1:0]  core;
        logic [DATA_W-1:0]  addr;
        logic [LEVEL_W-1:0] level;
    } start_req_t;

    // slot order of the stored words: 0 general, 1 standby, 2 entry
    function automatic logic [DATA_W-1:0] rw_reset(int idx);
        return (idx == 0) ? 32'h20 : 32'h0;
    endfunction

    function automatic reg_hit_t decode_offset(logic [ADDR_W-1:0] off);
        reg_hit_t          h;
        logic [ADDR_W-1:0] rel;
        h.sel  = SEL_NONE;
        h.core = '0;
        rel    = off - OFF_CORE_BASE;
        if (off[1:0] == 2'b00) begin
            if (off == OFF_CLUSTER_RST || off == OFF_SYS_RST) h.sel = SEL_GLOBAL_RST;
            else if (off == OFF_CLKGATE)                      h.sel = SEL_CLKGATE;
            else if (off == OFF_GEN)                          h.sel = SEL_GEN;
            else if (off == OFF_STBY)                         h.sel = SEL_STBY;
            else if (off == OFF_ENTRY)                        h.sel = SEL_ENTRY;
            else if (off == OFF_DBG || off == OFF_CNT_CTL ||
                     off == OFF_CNT_LO || off == OFF_CNT_HI)  h.sel = SEL_UNIMPL;
            else if (off >= OFF_CORE_BASE && off < OFF_CORE_END) begin
                h.core = rel[STRIDE_LSB +: CORE_W];
                case (rel[STRIDE_LSB-1:0])
                    6'h00:   h.sel = SEL_CORE_RST;
                    6'h04:   h.sel = SEL_CORE_CTRL;
                    6'h08:   h.sel = SEL_CORE_STAT;
                    default: h.sel = SEL_NONE;
                endcase
            end
        end
        return h;
    endfunction

endpackage

// File: rtl/cpucfg_decode.sv
module cpucfg_decode
    import cpucfg_pkg::*;
(
    input  logic              access,
    input  logic [ADDR_W-1:0] offset,
    output reg_hit_t          hit,
    output logic              err,
    output logic              unimpl
);
    always_comb begin
        hit    = decode_offset(offset);
        err    = access && (hit.sel == SEL_NONE);
        unimpl = access && (hit.sel == SEL_UNIMPL);
    end
endmodule

// File: rtl/cpucfg_regs.sv
module cpucfg_regs
    import cpucfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_hit_t          hit,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] entry
);
    logic [DATA_W-1:0] rw_q [NUM_RW];
    logic [NUM_RW-1:0] rw_sel;

    assign rw_sel = {hit.sel == SEL_ENTRY, hit.sel == SEL_STBY, hit.sel == SEL_GEN};

    for (genvar i = 0; i < NUM_RW; i++) begin : g_rw
        always_ff @(posedge clk) begin
            if (rst)                   rw_q[i] <= rw_reset(i);
            else if (wr_en && rw_sel[i]) rw_q[i] <= wdata;
        end
    end

    assign entry = rw_q[2];

    always_comb begin
        case (hit.sel)
            SEL_GLOBAL_RST: rdata = VAL_GLOBAL_RST;
            SEL_CORE_RST:   rdata = VAL_CORE_RST;
            SEL_CORE_STAT:  rdata = VAL_CORE_STAT;
            SEL_CLKGATE:    rdata = VAL_CLKGATE;
            SEL_GEN:        rdata = rw_q[0];
            SEL_STBY:       rdata = rw_q[1];
            SEL_ENTRY:      rdata = rw_q[2];
            default:        rdata = '0;
        endcase
    end
endmodule

// File: rtl/cpucfg_start.sv
module cpucfg_start
    import cpucfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic [CORE_W-1:0] core,
    input  logic [DATA_W-1:0] entry,
    output logic              valid,
    output start_req_t        req
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            req   <= '0;
        end else begin
            valid <= fire;
            if (fire) begin
                req.core  <= core;
                req.addr  <= entry;
                req.level <= START_LEVEL;
            end
        end
    end
endmodule

// File: rtl/cpucfg_top.sv
module cpucfg_top
    import cpucfg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                psel,
    input  logic                penable,
    input  logic                pwrite,
    input  logic [ADDR_W-1:0]   paddr,
    input  logic [DATA_W-1:0]   pwdata,
    output logic [DATA_W-1:0]   prdata,
    output logic                pslverr,
    output logic                unimpl_hit,
    output logic                start_valid,
    output logic [CORE_W-1:0]   start_core,
    output logic [DATA_W-1:0]   start_addr,
    output logic [LEVEL_W-1:0]  start_level
);
    logic              access, wr_en, fire;
    reg_hit_t          hit;
    logic [DATA_W-1:0] rdata, entry;
    start_req_t        req;

    assign access = psel && penable;
    assign wr_en  = access && pwrite;
    assign fire   = wr_en && (hit.sel == SEL_CORE_RST) && (pwdata != '0);

    cpucfg_decode u_dec (
        .access (access),
        .offset (paddr),
        .hit    (hit),
        .err    (pslverr),
        .unimpl (unimpl_hit)
    );

    cpucfg_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .hit   (hit),
        .wdata (pwdata),
        .rdata (rdata),
        .entry (entry)
    );

    cpucfg_start u_start (
        .clk   (clk),
        .rst   (rst),
        .fire  (fire),
        .core  (hit.core),
        .entry (entry),
        .valid (start_valid),
        .req   (req)
    );

    assign prdata      = access ? rdata : '0;
    assign start_core  = req.core;
    assign start_addr  = req.addr;
    assign start_level = req.level;
endmodule

// File: rtl/cpucfg_checker.sv
module cpucfg_checker
    import cpucfg_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                psel,
    input logic                penable,
    input logic                pwrite,
    input logic [ADDR_W-1:0]   paddr,
    input logic [DATA_W-1:0]   pwdata,
    input logic [DATA_W-1:0]   prdata,
    input logic                pslverr,
    input logic                unimpl_hit,
    input logic                start_valid,
    input logic [CORE_W-1:0]   start_core,
    input logic [LEVEL_W-1:0]  start_level
);
    logic core_rst_wr;
    assign core_rst_wr = psel && penable && pwrite && paddr[5:0] == 6'h00 &&
                         paddr >= OFF_CORE_BASE && paddr < OFF_CORE_END;

    p_start_cause_r3: assert property (@(posedge clk) disable iff (rst)
        start_valid |-> $past(core_rst_wr && pwdata != '0));

    p_start_level_r3: assert property (@(posedge clk) disable iff (rst)
        start_valid |-> start_level == 2'd3);

    p_start_core_r3: assert property (@(posedge clk) disable iff (rst)
        start_valid |-> start_core == $past(paddr[STRIDE_LSB +: CORE_W]) - 1'b1);

    p_zero_write_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (core_rst_wr && pwdata == '0) |=> !start_valid);

    p_single_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        start_valid |=> !start_valid);

    p_err_reads_zero_r7: assert property (@(posedge clk) disable iff (rst)
        pslverr |-> prdata == '0);

    p_flags_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
        !(pslverr && unimpl_hit));

    p_flags_in_access_r8: assert property (@(posedge clk) disable iff (rst)
        (pslverr || unimpl_hit) |-> (psel && penable));
endmodule

bind cpucfg_top cpucfg_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .psel        (psel),
    .penable     (penable),
    .pwrite      (pwrite),
    .paddr       (paddr),
    .pwdata      (pwdata),
    .prdata      (prdata),
    .pslverr     (pslverr),
    .unimpl_hit  (unimpl_hit),
    .start_valid (start_valid),
    .start_core  (start_core),
    .start_level (start_level)
);

// File: tb/sim_cpucfg_top.sv
`timescale 1ns/1ps
module sim_cpucfg_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        psel, penable, pwrite;
    logic [9:0]  paddr;
    logic [31:0] pwdata, prdata, start_addr;
    logic        pslverr, unimpl_hit, start_valid;
    logic [1:0]  start_core, start_level;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_gen, m_stby, m_entry;

    always #2.5 clk = ~clk;

    cpucfg_top u0 (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pslverr(pslverr),
        .unimpl_hit(unimpl_hit), .start_valid(start_valid), .start_core(start_core),
        .start_addr(start_addr), .start_level(start_level)
    );

    // class: 0 undecoded, 1 fixed, 2 stored, 3 reserved, 4 core reset
    function automatic int kind(int a);
        int r;
        if (a % 4 != 0) return 0;
        case (a)
            'h000, 'h140, 'h144: return 1;
            'h184, 'h1A0, 'h1A4: return 2;
            'h1E4, 'h280, 'h284, 'h288: return 3;
            default: ;
        endcase
        if (a >= 'h40 && a < 'h140) begin
            r = (a - 'h40) % 64;
            if (r == 0) return 4;
            if (r == 4 || r == 8) return 1;
        end
        return 0;
    endfunction

    function automatic logic [31:0] exp_rd(int a);
        int k = kind(a);
        if (k == 4) return 32'h3;
        if (k == 2) return (a == 'h184) ? m_gen : (a == 'h1A0) ? m_stby : m_entry;
        if (k == 1) begin
            if (a == 'h144) return 32'h10F;
            if (a == 'h000 || a == 'h140) return 32'h1;
            return ((a - 'h40) % 64 == 8) ? 32'h1 : 32'h0;
        end
        return 32'h0;
    endfunction

    function automatic string tag(int a);
        case (kind(a))
            0: return "R7";
            1: return "R5";
            2: return "R2";
            3: return "R6";
            default: return "R3";
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic flags(int a);
        chk({tag(a), "/R8 pslverr"}, {31'b0, pslverr}, {31'b0, kind(a) == 0});
        chk({tag(a), "/R8 unimpl"},  {31'b0, unimpl_hit}, {31'b0, kind(a) == 3});
    endtask

    task automatic bus(bit wr, int a, logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = 10'(a); pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        #1;
        flags(a);
        if (!wr) chk({tag(a), " read"}, prdata, exp_rd(a));
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        if (wr && kind(a) == 4 && d != 0) begin
            chk("R3 start_valid", {31'b0, start_valid}, 32'h1);
            chk("R3 start_core",  {30'b0, start_core}, 32'((a - 'h40) / 64));
            chk("R3 start_addr",  start_addr, m_entry);
            chk("R3 start_level", {30'b0, start_level}, 32'h3);
            @(negedge clk);
            chk("R3 pulse width", {31'b0, start_valid}, 32'h0);
        end else begin
            chk("R4 no start", {31'b0, start_valid}, 32'h0);
        end
        if (wr && kind(a) == 2) begin
            if (a == 'h184) m_gen = d;
            else if (a == 'h1A0) m_stby = d;
            else m_entry = d;
        end
    endtask

    task automatic rd_all_stored();
        bus(0, 'h184, 0); bus(0, 'h1A0, 0); bus(0, 'h1A4, 0);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        int pick [14] = '{'h000, 'h040, 'h044, 'h048, 'h0C0, 'h108, 'h140, 'h144,
                          'h184, 'h1A0, 'h1A4, 'h1E4, 'h288, 'h041};
        seed = $urandom(32'h5EED);
        psel = 0; penable = 0; pwrite = 0; paddr = 0; pwdata = 0;
        m_gen = 32'h20; m_stby = 0; m_entry = 0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R4 reset start_valid", {31'b0, start_valid}, 32'h0);
        // R1 reset values
        chk("R1 gen reset", 32'h20, m_gen);
        rd_all_stored();
        // R2 full-width storage
        bus(1, 'h184, 32'hFFFF_FFFF); bus(1, 'h1A0, 32'hA5A5_5A5A);
        bus(1, 'h1A4, 32'h8000_0001); rd_all_stored();
        // R3 one start per core, distinct entry addresses
        for (int c = 0; c < 4; c++) begin
            bus(1, 'h1A4, 32'h4000_0000 + 32'(c) * 32'h100);
            bus(1, 'h40 + c * 'h40, 32'(c + 1));
        end
        // R4 zero writes
        for (int c = 0; c < 4; c++) bus(1, 'h40 + c * 'h40, 0);
        // R5 fixed words ignore writes, R6 reserved, R7 misaligned/undecoded
        foreach (pick[i]) begin
            bus(1, pick[i], 32'hDEAD_BEEF);
            bus(0, pick[i], 0);
        end
        bus(0, 'h1A6, 0); bus(1, 'h1A5, 32'h1234_5678); bus(0, 'h04C, 0);
        bus(1, 'h3FC, 32'h1); bus(0, 'h280, 0); bus(0, 'h284, 0);
        rd_all_stored();
        // random mix
        for (int n = 0; n < 400; n++) begin
            int a;
            bit wr;
            if ($urandom % 2) a = pick[$urandom % 14];
            else a = $urandom % 1024;
            if ($urandom % 4 == 0) a = a & ~3;
            wr = $urandom % 2;
            bus(wr, a, ($urandom % 3 == 0) ? 32'h0 : $urandom);
        end
        rd_all_stored();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule